// File: doc/BRIEF.md
# External Bus Mastership Controller

This block is the requesting side of a shared external bus that an outside arbiter controls. It watches the local access stream and raises an active-low bus request whenever an access bound for the external bus is pending. It samples an active-low grant from the arbiter and takes part in a pulled-up, open-drain bus-busy line. It also raises a mastership flag that the local memory controller uses to start external cycles.

After a grant, the block waits for the busy line to go free. It then claims the bus by pulling busy low. It stays master while idle ("parking"), so later accesses need no fresh arbitration. When the grant is withdrawn, it gives the bus up only at a bus-cycle boundary. To release the line it drives busy high for one clock and then stops driving it.

A software hold bit can force the request on. A low-power indication either forces the request off or freezes it. An asynchronous-arbitration mode passes grant and busy through an internal synchronizer. In that mode a grant that follows a grant removal too closely is ignored.

Top module: `busmst_ctrl`

## Requirements
- R1: `req_no` goes low one clock after an external access is pending (`acc_valid_i`=1 and `acc_external_i`=1). It goes high one clock after the access ends, whether or not the block is master.
- R2: With `req_hold_i`=1 and `lowpwr_i`=0, `req_no` is low one clock later even with no access pending.
- R3: An access with `acc_external_i`=0 has no effect on `req_no`.
- R4: While `rst_ni` is low, `req_no`=1, `master_o`=0 and `busy_oe_o`=0 (bus-slave state).
- R5: As slave, the block becomes master at the clock edge that ends a cycle in which all three of the following hold: the grant seen is active, the busy line seen is high, and the request is asserted. It then sets `master_o`=1 and drives busy low (`busy_oe_o`=1, `busy_do_o`=0).
- R6: As master, the block leaves mastership only at the edge that ends a cycle in which the grant seen is inactive and `cycle_end_i`=1. It stays master otherwise, even with external accesses still pending.
- R7: While master with the grant still active and no access pending, the block keeps `master_o`=1 and busy driven low (parking).
- R8: On leaving mastership, the block drives busy high (`busy_oe_o`=1, `busy_do_o`=1) for exactly one clock. It then sets `busy_oe_o`=0.
- R9: With `async_arb_i`=1, grant and busy are seen through a chain of SYNC_STAGES flops. For GRANT_GAP clocks after the synchronized grant falls, a grant assertion is ignored.
- R10: With `lowpwr_i`=1 and `req_hold_i`=0, `req_no` goes high. With `lowpwr_i`=1 and `req_hold_i`=1, `req_no` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| acc_valid_i | input | 1 | A local access is pending |
| acc_external_i | input | 1 | The pending access targets the external bus (0 = on-chip) |
| cycle_end_i | input | 1 | Bus-cycle boundary; held high while no external cycle runs |
| req_hold_i | input | 1 | Software control that keeps the request asserted |
| async_arb_i | input | 1 | Selects synchronized grant/busy sampling with an inter-grant gap |
| lowpwr_i | input | 1 | Stop/wait indication |
| grant_ni | input | 1 | Active-low grant from the arbiter |
| busy_ni | input | 1 | Sampled level of the active-low busy line |
| req_no | output | 1 | Active-low bus request |
| busy_oe_o | output | 1 | Drive enable for the busy line |
| busy_do_o | output | 1 | Value driven on the busy line when enabled |
| master_o | output | 1 | Block currently owns the external bus |

## Verification
The grant removal and the bus-cycle boundary can coincide. The bench provokes this while the block is master: it deasserts `grant_ni` and raises `cycle_end_i` in the same cycle. It then expects the one-clock high drive at the very next edge. The bench also makes grant reassertion overlap the release pulse and the synchronizer latency in asynchronous mode. In that case mastership must be delayed to the end of the gap window, not just until busy clears.

// File: rtl/busmst_pkg.sv
package busmst_pkg;
   typedef enum logic [1:0] {
      BM_SLAVE   = 2'd0,
      BM_OWN     = 2'd1,
      BM_RELEASE = 2'd2
   } bm_state_e;
endpackage

// File: rtl/busmst_sense.sv
module busmst_sense #(
   parameter int SYNC_STAGES = 2,
   parameter int GRANT_GAP   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   input  logic grant_act_i,
   input  logic busy_act_i,
   output logic grant_o,
   output logic busy_o
);
   localparam int GAP_W = $clog2(GRANT_GAP + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("busmst_sense: SYNC_STAGES must be at least 2");
   end
   if (GRANT_GAP < 1) begin : g_bad_gap
      $error("busmst_sense: GRANT_GAP must be at least 1");
   end

   logic [SYNC_STAGES-1:0] gnt_s;
   logic [SYNC_STAGES-1:0] bsy_s;

   for (genvar st = 0; st < SYNC_STAGES; st++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            gnt_s[st] <= 1'b0;
            bsy_s[st] <= 1'b0;
         end else if (st == 0) begin
            gnt_s[st] <= grant_act_i;
            bsy_s[st] <= busy_act_i;
         end else begin
            gnt_s[st] <= gnt_s[(st == 0) ? 0 : st-1];
            bsy_s[st] <= bsy_s[(st == 0) ? 0 : st-1];
         end
      end
   end

   logic             gnt_raw;
   logic             gnt_prev;
   logic             gnt_fall;
   logic [GAP_W-1:0] gap_cnt;

   assign gnt_raw  = async_i ? gnt_s[SYNC_STAGES-1] : grant_act_i;
   assign busy_o   = async_i ? bsy_s[SYNC_STAGES-1] : busy_act_i;
   assign gnt_fall = gnt_prev & ~gnt_raw;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gnt_prev <= 1'b0;
         gap_cnt  <= '0;
      end else begin
         gnt_prev <= gnt_raw;
         if (async_i && gnt_fall)
            gap_cnt <= GAP_W'(GRANT_GAP);
         else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - GAP_W'(1);
      end
   end

   assign grant_o = gnt_raw & (~async_i | (gap_cnt == '0));

   // R9
   gap_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (async_i && gnt_fall) |=> (!grant_o || !async_i))
      else $error("grant accepted inside the inter-grant gap");
endmodule

// File: rtl/busmst_req.sv
module busmst_req (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic acc_valid_i,
   input  logic acc_external_i,
   input  logic req_hold_i,
   input  logic lowpwr_i,
   output logic req_o
);
   logic need_ext;
   logic req_q;
   logic req_d;

   assign need_ext = acc_valid_i & acc_external_i;

   always_comb begin
      if (lowpwr_i)
         req_d = req_hold_i & req_q;
      else
         req_d = need_ext | req_hold_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= req_d;
   end

   assign req_o = req_q;

   // R3
   onchip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_hold_i && !lowpwr_i && !(acc_valid_i && acc_external_i)) |=> !req_o)
      else $error("request raised without an external demand");
   // R2
   hold_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_hold_i && !lowpwr_i) |=> req_o)
      else $error("hold bit did not keep the request");
   // R10
   lowpwr_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lowpwr_i && req_hold_i) |=> $stable(req_o))
      else $error("request changed while frozen in low power");
endmodule

// File: rtl/busmst_fsm.sv
module busmst_fsm
   import busmst_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic grant_i,
   input  logic busy_i,
   input  logic req_i,
   input  logic cycle_end_i,
   output logic master_o,
   output logic busy_oe_o,
   output logic busy_do_o
);
   bm_state_e state_q;
   bm_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         BM_SLAVE:   if (grant_i && !busy_i && req_i) state_d = BM_OWN;
         BM_OWN:     if (!grant_i && cycle_end_i)     state_d = BM_RELEASE;
         BM_RELEASE: state_d = BM_SLAVE;
         default:    state_d = BM_SLAVE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= BM_SLAVE;
      else         state_q <= state_d;
   end

   assign master_o  = (state_q == BM_OWN);
   assign busy_oe_o = (state_q != BM_SLAVE);
   assign busy_do_o = (state_q == BM_RELEASE);

   // R5
   take_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(master_o) |-> $past(grant_i && !busy_i && req_i))
      else $error("mastership taken while busy, ungranted or unrequested");
   // R6
   hold_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_o && !(cycle_end_i && !grant_i)) |=> master_o)
      else $error("mastership dropped away from a cycle boundary");
   // R8
   release_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(master_o) |-> (busy_oe_o && busy_do_o))
      else $error("busy line not driven high on release");
   // R8
   release_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_oe_o && busy_do_o) |=> !busy_oe_o)
      else $error("busy line driven high for more than one clock");
endmodule

// File: rtl/busmst_ctrl.sv
module busmst_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int GRANT_GAP   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic acc_valid_i,
   input  logic acc_external_i,
   input  logic cycle_end_i,
   input  logic req_hold_i,
   input  logic async_arb_i,
   input  logic lowpwr_i,
   input  logic grant_ni,
   input  logic busy_ni,
   output logic req_no,
   output logic busy_oe_o,
   output logic busy_do_o,
   output logic master_o
);
   logic grant_seen;
   logic busy_seen;
   logic req_act;

   busmst_sense #(
      .SYNC_STAGES (SYNC_STAGES),
      .GRANT_GAP   (GRANT_GAP)
   ) u_sense (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .async_i     (async_arb_i),
      .grant_act_i (~grant_ni),
      .busy_act_i  (~busy_ni),
      .grant_o     (grant_seen),
      .busy_o      (busy_seen)
   );

   busmst_req u_req (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .acc_valid_i    (acc_valid_i),
      .acc_external_i (acc_external_i),
      .req_hold_i     (req_hold_i),
      .lowpwr_i       (lowpwr_i),
      .req_o          (req_act)
   );

   busmst_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .grant_i     (grant_seen),
      .busy_i      (busy_seen),
      .req_i       (req_act),
      .cycle_end_i (cycle_end_i),
      .master_o    (master_o),
      .busy_oe_o   (busy_oe_o),
      .busy_do_o   (busy_do_o)
   );

   assign req_no = ~req_act;
endmodule

// File: tb/busmst_ctrl_tb.sv
module busmst_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic acc_valid = 1'b1, acc_external = 1'b1, cycle_end = 1'b0;
   logic req_hold = 1'b0, async_arb = 1'b0, lowpwr = 1'b0;
   logic grant_ni = 1'b1, other_busy = 1'b0;
   logic busy_ni, req_no, busy_oe, busy_do, master;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign busy_ni = busy_oe ? busy_do : ~other_busy;

   busmst_ctrl #(.SYNC_STAGES(2), .GRANT_GAP(4)) dut_i (
      .clk_i (clk), .rst_ni (rst_ni),
      .acc_valid_i (acc_valid), .acc_external_i (acc_external),
      .cycle_end_i (cycle_end), .req_hold_i (req_hold),
      .async_arb_i (async_arb), .lowpwr_i (lowpwr),
      .grant_ni (grant_ni), .busy_ni (busy_ni),
      .req_no (req_no), .busy_oe_o (busy_oe), .busy_do_o (busy_do),
      .master_o (master)
   );

   typedef struct {
      string tag;
      logic  req_n;
      logic  mst;
      logic  oe;
      logic  dov;
   } exp_t;

   exp_t sb_q[$];

   task automatic tick(input string tag, input logic rq, input logic m,
                       input logic oe, input logic dv);
      exp_t it;
      @(posedge clk);
      it.tag = tag; it.req_n = ~rq; it.mst = m; it.oe = oe; it.dov = dv;
      sb_q.push_back(it);
      @(negedge clk);
      #2;
   endtask

   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         checks++;
         if (req_no !== it.req_n || master !== it.mst || busy_oe !== it.oe ||
             (it.oe && busy_do !== it.dov)) begin
            errors++;
            $display("FAIL %s: got req_n=%b mst=%b oe=%b do=%b, expected req_n=%b mst=%b oe=%b do=%b",
                     it.tag, req_no, master, busy_oe, busy_do,
                     it.req_n, it.mst, it.oe, it.dov);
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R4: reset holds slave state even with an external demand
      tick("R4", 0, 0, 0, 0);
      tick("R4", 0, 0, 0, 0);
      rst_ni = 1'b1;
      acc_external = 1'b0;
      tick("R3", 0, 0, 0, 0);
      acc_external = 1'b1;
      tick("R1", 1, 0, 0, 0);
      // R5: grant present but another master still holds busy
      grant_ni = 1'b0; other_busy = 1'b1;
      tick("R5", 1, 0, 0, 0);
      tick("R5", 1, 0, 0, 0);
      other_busy = 1'b0;
      tick("R5", 1, 1, 1, 0);
      // R1 drop while master, R7 parking
      acc_valid = 1'b0;
      tick("R1", 0, 1, 1, 0);
      tick("R7", 0, 1, 1, 0);
      // R6: grant gone, instruction still has external cycles, no boundary yet
      acc_valid = 1'b1; grant_ni = 1'b1; cycle_end = 1'b0;
      tick("R6", 1, 1, 1, 0);
      tick("R6", 1, 1, 1, 0);
      cycle_end = 1'b1;
      tick("R8", 1, 0, 1, 1);
      cycle_end = 1'b0;
      tick("R8", 1, 0, 0, 0);
      // grant removal and boundary in the same cycle
      grant_ni = 1'b0;
      tick("R5", 1, 1, 1, 0);
      grant_ni = 1'b1; cycle_end = 1'b1;
      tick("R6", 1, 0, 1, 1);
      cycle_end = 1'b0;
      tick("R8", 1, 0, 0, 0);
      // R2 hold, R10 low power
      acc_valid = 1'b0; req_hold = 1'b1;
      tick("R2", 1, 0, 0, 0);
      lowpwr = 1'b1;
      tick("R10", 1, 0, 0, 0);
      tick("R10", 1, 0, 0, 0);
      req_hold = 1'b0;
      tick("R10", 0, 0, 0, 0);
      req_hold = 1'b1;
      tick("R10", 0, 0, 0, 0);
      lowpwr = 1'b0;
      tick("R2", 1, 0, 0, 0);
      // R9: synchronized mode
      req_hold = 1'b0; async_arb = 1'b1; acc_valid = 1'b1; acc_external = 1'b1;
      tick("R9", 1, 0, 0, 0);
      grant_ni = 1'b0;
      tick("R9", 1, 0, 0, 0);
      tick("R9", 1, 0, 0, 0);
      tick("R9", 1, 1, 1, 0);
      grant_ni = 1'b1; cycle_end = 1'b1;
      tick("R9", 1, 1, 1, 0);
      tick("R9", 1, 1, 1, 0);
      grant_ni = 1'b0;
      tick("R9", 1, 0, 1, 1);
      tick("R9", 1, 0, 0, 0);
      tick("R9", 1, 0, 0, 0);
      tick("R9", 1, 0, 0, 0);
      tick("R9", 1, 0, 0, 0);
      tick("R9", 1, 1, 1, 0);
      @(posedge clk);
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule